// File: doc/BRIEF.md
# Oscillator-Loss Supervisor for Low-Power Wait

This block decides how the chip responds when the crystal oscillator stops while the core sits in a low-power wait state. The response depends on three enable bits. With the monitor disabled, the loss is ignored. With the monitor enabled and self-clocking disabled, the block requests an immediate monitor reset. With both enabled, the block keeps the core waiting and powers the regulator and PLL. It then switches to self-clocking, records the event in a sticky flag and starts an oscillator quality check.

A quality check passes once `CHECK_LEN` consecutive oscillator ticks are counted with no clock-fail indication in between. A failure indication restarts the count from zero. A later wakeup interrupt or external reset ends the wait. The system clock chosen at that moment is the oscillator if it has recovered and the PLL if it has not. When the core leaves on the PLL, checks keep running, without limit if needed, until one passes. The clock select then returns to the oscillator.

The clock detector, oscillator and PLL are modelled by the `clk_fail`, `osc_tick` and `pll_on` signals. All outputs are registered and change one clock after the inputs that cause them.

Top module: `clkloss_sup`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs are as follows. `pll_on` and `vreg_on` are 1. `sysclk_pll` is 0 (oscillator). `scm_active`, `scm_flag`, `scm_irq`, `mon_rst_req`, `rst_seq_start` and `wait_exit` are 0.
- R2: When `mon_en` is 0, `clk_fail` during wait changes no output and does not end the wait.
- R3: When `mon_en` is 1 and `scm_en` is 0, `clk_fail` during wait (with no exit request) gives a single-cycle `mon_rst_req` on the next clock, and the block returns to the running state.
- R4: When `mon_en` and `scm_en` are both 1, `clk_fail` during wait sets `scm_active`, `pll_on`, `vreg_on` and `scm_flag` on the next clock, and gives no `wait_exit`.
- R5: While self-clocking, a check passes on the clock that samples the `CHECK_LEN`-th consecutive `osc_tick`. Any `clk_fail` resets the tick count to zero.
- R6: When a check passes during wait, `scm_active` clears and the wait continues. `vreg_on` stays 1 and `pll_on` becomes the inverse of `pll_off_wait`.
- R7: In wait with the oscillator good, `ext_rst` or `wake_irq` gives a single-cycle `wait_exit` with `sysclk_pll` at 0. `ext_rst` also gives a single-cycle `rst_seq_start`.
- R8: In wait while self-clocking, an exit request sets `sysclk_pll` to 1 and keeps `scm_active` at 1. The next passing check clears both.
- R9: `scm_flag` is sticky and is cleared by `flag_clr`; a set in the same cycle wins. `scm_irq` equals `scm_flag` AND `scm_irq_en`, one clock after the cause.
- R10: When `ext_rst` and `wake_irq` arrive together, the exit takes the reset path, with `rst_seq_start` set.
- R11: `sysclk_pll` changes only on a wait-exit decision or on a check passing after a self-clocked exit.
- R12: In wait without self-clocking since entry, `vreg_on` is 0 and `pll_on` is the inverse of `pll_off_wait`. Outside wait both are 1.
- R13: `wake_irq`, `ext_rst` and `clk_fail` in the running state produce no pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock mode enable |
| scm_irq_en | input | 1 | Self-clock interrupt enable |
| clk_fail | input | 1 | Oscillator failure indication |
| osc_tick | input | 1 | One pulse per counted oscillator edge |
| wake_irq | input | 1 | Wakeup interrupt request |
| ext_rst | input | 1 | External reset request |
| pll_off_wait | input | 1 | 1: PLL is switched off during wait |
| core_wait | input | 1 | Core requests entry into wait |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| mon_rst_req | output | 1 | Clock monitor reset request pulse |
| rst_seq_start | output | 1 | Reset sequence start pulse |
| wait_exit | output | 1 | Wait-exit decision pulse |
| scm_active | output | 1 | Self-clock mode active |
| sysclk_pll | output | 1 | System clock select, 1 = PLL |
| pll_on | output | 1 | PLL enable |
| vreg_on | output | 1 | Regulator enable |
| scm_flag | output | 1 | Sticky self-clock event flag |
| scm_irq | output | 1 | Self-clock interrupt |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `clk_fail` and `osc_tick` are already reduced to clock-domain pulses, so one tick counts once. The stimulus changes inputs only on the falling edge. It drives every tick and failure as a clean level per clock, including ticks every cycle and every other cycle. A behavioural model follows the same inputs, and every output is compared with it on each cycle.

// File: rtl/clkloss_sup_pkg.sv
package clkloss_sup_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_WAIT_SC = 2'd2,
    ST_RUN_SC  = 2'd3
  } sup_state_t;
endpackage

// File: rtl/clkloss_qcheck.sv
module clkloss_qcheck #(
  parameter int CHECK_LEN = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic pass
);
  localparam int CW = (CHECK_LEN > 1) ? $clog2(CHECK_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHECK_LEN - 1);

  logic [CW-1:0] cnt;

  assign pass = run & tick & ~restart & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= pass ? '0 : cnt + 1'b1;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && $past(tick) && !$past(restart) && !$past(pass))
      |-> (cnt == $past(cnt) + 1'b1));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt == '0));
endmodule

// File: rtl/clkloss_flag.sv
module clkloss_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_n;

  always_comb begin
    flag_n = flag;
    if (set)      flag_n = 1'b1;
    else if (clr) flag_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n & irq_en;
    end
  end

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flag) && !$past(clr)) |-> flag);
endmodule

// File: rtl/clkloss_ctrl.sv
module clkloss_ctrl
  import clkloss_sup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mon_en,
  input  logic scm_en,
  input  logic clk_fail,
  input  logic pass,
  input  logic wake_irq,
  input  logic ext_rst,
  input  logic pll_off_wait,
  input  logic core_wait,
  output logic chk_run,
  output logic set_flag,
  output logic scm_active,
  output logic mon_rst_req,
  output logic rst_seq_start,
  output logic wait_exit,
  output logic sysclk_pll,
  output logic pll_on,
  output logic vreg_on
);
  sup_state_t st, nxt;
  logic keep_q, keep_n, sel_n, mrr_n, rss_n, ex_n, pll_n, vreg_n;

  always_comb begin
    nxt      = st;
    keep_n   = keep_q;
    sel_n    = sysclk_pll;
    mrr_n    = 1'b0;
    rss_n    = 1'b0;
    ex_n     = 1'b0;
    set_flag = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (core_wait) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (ext_rst || wake_irq) begin
          nxt    = ST_RUN;
          ex_n   = 1'b1;
          rss_n  = ext_rst;
          sel_n  = 1'b0;
          keep_n = 1'b0;
        end else if (clk_fail && mon_en) begin
          if (scm_en) begin
            nxt      = ST_WAIT_SC;
            set_flag = 1'b1;
            keep_n   = 1'b1;
          end else begin
            nxt    = ST_RUN;
            mrr_n  = 1'b1;
            keep_n = 1'b0;
          end
        end
      end
      ST_WAIT_SC: begin
        if (ext_rst || wake_irq) begin
          nxt    = ST_RUN_SC;
          ex_n   = 1'b1;
          rss_n  = ext_rst;
          sel_n  = 1'b1;
          keep_n = 1'b0;
        end else if (pass) begin
          nxt = ST_WAIT;
        end
      end
      ST_RUN_SC: begin
        if (pass) begin
          nxt   = ST_RUN;
          sel_n = 1'b0;
        end
      end
      default: nxt = ST_RUN;
    endcase
    pll_n  = (nxt == ST_WAIT) ? ~pll_off_wait : 1'b1;
    vreg_n = (nxt == ST_WAIT) ? keep_n : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RUN;
      keep_q        <= 1'b0;
      sysclk_pll    <= 1'b0;
      mon_rst_req   <= 1'b0;
      rst_seq_start <= 1'b0;
      wait_exit     <= 1'b0;
      pll_on        <= 1'b1;
      vreg_on       <= 1'b1;
    end else begin
      st            <= nxt;
      keep_q        <= keep_n;
      sysclk_pll    <= sel_n;
      mon_rst_req   <= mrr_n;
      rst_seq_start <= rss_n;
      wait_exit     <= ex_n;
      pll_on        <= pll_n;
      vreg_on       <= vreg_n;
    end
  end

  assign chk_run    = (st == ST_WAIT_SC) || (st == ST_RUN_SC);
  assign scm_active = chk_run;

  // R3
  mon_rst_src_chk: assert property (@(posedge clk) disable iff (rst)
    mon_rst_req |-> $past(mon_en && !scm_en && clk_fail && st == ST_WAIT));

  // R7
  rst_seq_exit_chk: assert property (@(posedge clk) disable iff (rst)
    rst_seq_start |-> wait_exit);

  // R10
  reset_prio_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ext_rst && (st == ST_WAIT || st == ST_WAIT_SC))
      |-> (rst_seq_start && wait_exit));

  // R11
  sel_change_chk: assert property (@(posedge clk) disable iff (rst)
    (sysclk_pll != $past(sysclk_pll)) |-> $past(st == ST_WAIT_SC || st == ST_RUN_SC));

  // R4
  scm_power_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_SC) |-> (pll_on && vreg_on));
endmodule

// File: rtl/clkloss_sup.sv
module clkloss_sup #(
  parameter int CHECK_LEN = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_en,
  input  logic scm_en,
  input  logic scm_irq_en,
  input  logic clk_fail,
  input  logic osc_tick,
  input  logic wake_irq,
  input  logic ext_rst,
  input  logic pll_off_wait,
  input  logic core_wait,
  input  logic flag_clr,
  output logic mon_rst_req,
  output logic rst_seq_start,
  output logic wait_exit,
  output logic scm_active,
  output logic sysclk_pll,
  output logic pll_on,
  output logic vreg_on,
  output logic scm_flag,
  output logic scm_irq
);
  logic chk_run, pass, set_flag;

  clkloss_qcheck #(.CHECK_LEN(CHECK_LEN)) u_qcheck (
    .clk(clk), .rst(rst), .run(chk_run), .restart(clk_fail),
    .tick(osc_tick), .pass(pass)
  );

  clkloss_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mon_en(mon_en), .scm_en(scm_en),
    .clk_fail(clk_fail), .pass(pass), .wake_irq(wake_irq),
    .ext_rst(ext_rst), .pll_off_wait(pll_off_wait), .core_wait(core_wait),
    .chk_run(chk_run), .set_flag(set_flag), .scm_active(scm_active),
    .mon_rst_req(mon_rst_req), .rst_seq_start(rst_seq_start),
    .wait_exit(wait_exit), .sysclk_pll(sysclk_pll), .pll_on(pll_on),
    .vreg_on(vreg_on)
  );

  clkloss_flag u_flag (
    .clk(clk), .rst(rst), .set(set_flag), .clr(flag_clr),
    .irq_en(scm_irq_en), .flag(scm_flag), .irq(scm_irq)
  );

  // R4
  flag_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scm_active) |-> scm_flag);
endmodule

// File: tb/clkloss_sup_tb.sv
module clkloss_sup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 4096;

  logic clk = 1'b0, rst = 1'b1;
  logic mon_en = 0, scm_en = 0, scm_irq_en = 0, clk_fail = 0, osc_tick = 0;
  logic wake_irq = 0, ext_rst = 0, pll_off_wait = 0, core_wait = 0, flag_clr = 0;
  logic mon_rst_req, rst_seq_start, wait_exit, scm_active, sysclk_pll;
  logic pll_on, vreg_on, scm_flag, scm_irq;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkloss_sup #(.CHECK_LEN(LEN)) u_dut (
    .clk(clk), .rst(rst), .mon_en(mon_en), .scm_en(scm_en),
    .scm_irq_en(scm_irq_en), .clk_fail(clk_fail), .osc_tick(osc_tick),
    .wake_irq(wake_irq), .ext_rst(ext_rst), .pll_off_wait(pll_off_wait),
    .core_wait(core_wait), .flag_clr(flag_clr), .mon_rst_req(mon_rst_req),
    .rst_seq_start(rst_seq_start), .wait_exit(wait_exit),
    .scm_active(scm_active), .sysclk_pll(sysclk_pll), .pll_on(pll_on),
    .vreg_on(vreg_on), .scm_flag(scm_flag), .scm_irq(scm_irq)
  );

  // behavioural reference: 0 running, 1 waiting, 2 waiting self-clocked, 3 running self-clocked
  int ms = 0, mcnt = 0, nx;
  bit m_mrr, m_rss, m_ex, m_sel, m_pll = 1, m_vreg = 1, m_keep, m_flag, m_irq, mpass, setf;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mcnt = 0; m_mrr = 0; m_rss = 0; m_ex = 0; m_sel = 0;
      m_pll = 1; m_vreg = 1; m_keep = 0; m_flag = 0; m_irq = 0;
    end else begin
      mpass = (ms >= 2) && osc_tick && !clk_fail && (mcnt == LEN - 1);
      nx = ms; setf = 0; m_mrr = 0; m_rss = 0; m_ex = 0;
      if (ms == 0) begin
        if (core_wait) nx = 1;
      end else if (ms == 1) begin
        if (ext_rst || wake_irq) begin
          nx = 0; m_ex = 1; m_rss = ext_rst; m_sel = 0; m_keep = 0;
        end else if (clk_fail && mon_en) begin
          if (scm_en) begin nx = 2; setf = 1; m_keep = 1; end
          else begin nx = 0; m_mrr = 1; m_keep = 0; end
        end
      end else if (ms == 2) begin
        if (ext_rst || wake_irq) begin
          nx = 3; m_ex = 1; m_rss = ext_rst; m_sel = 1; m_keep = 0;
        end else if (mpass) nx = 1;
      end else begin
        if (mpass) begin nx = 0; m_sel = 0; end
      end
      if (ms < 2 || clk_fail) mcnt = 0;
      else if (osc_tick) mcnt = mpass ? 0 : mcnt + 1;
      ms = nx;
      m_pll  = (ms == 1) ? !pll_off_wait : 1'b1;
      m_vreg = (ms == 1) ? m_keep : 1'b1;
      if (setf) m_flag = 1; else if (flag_clr) m_flag = 0;
      m_irq = m_flag && scm_irq_en;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic cmp(input logic a, input bit e, input string req);
    chk(a === e, req, int'(a), int'(e));
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp(mon_rst_req, m_mrr, "R3 mon_rst_req");
      cmp(rst_seq_start, m_rss, "R7 rst_seq_start");
      cmp(wait_exit, m_ex, "R7 wait_exit");
      cmp(scm_active, ms >= 2, "R4 scm_active");
      cmp(sysclk_pll, m_sel, "R11 sysclk_pll");
      cmp(pll_on, m_pll, "R12 pll_on");
      cmp(vreg_on, m_vreg, "R12 vreg_on");
      cmp(scm_flag, m_flag, "R9 scm_flag");
      cmp(scm_irq, m_irq, "R9 scm_irq");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_fail();
    clk_fail = 1; step(1); clk_fail = 0;
  endtask

  task automatic enter_wait();
    core_wait = 1; step(1); core_wait = 0;
  endtask

  initial begin
    step(3);
    // R1 reset state
    cmp(pll_on, 1, "R1 pll_on"); cmp(vreg_on, 1, "R1 vreg_on");
    cmp(sysclk_pll, 0, "R1 sysclk"); cmp(scm_active, 0, "R1 scm");
    cmp(scm_flag, 0, "R1 flag"); cmp(mon_rst_req, 0, "R1 mrr");
    rst = 0; step(1);
    cmp(wait_exit, 0, "R1 exit"); cmp(pll_on, 1, "R1 pll_on");

    // R13 requests in running state
    wake_irq = 1; ext_rst = 1; clk_fail = 1; step(1);
    wake_irq = 0; ext_rst = 0; clk_fail = 0;
    cmp(wait_exit, 0, "R13 exit"); cmp(rst_seq_start, 0, "R13 rss");
    cmp(scm_active, 0, "R13 scm");

    // R2 monitor disabled
    pll_off_wait = 1; enter_wait();
    cmp(vreg_on, 0, "R12 vreg in wait"); cmp(pll_on, 0, "R12 pll in wait");
    pulse_fail(); step(2);
    cmp(mon_rst_req, 0, "R2 mrr"); cmp(scm_active, 0, "R2 scm");
    cmp(wait_exit, 0, "R2 no exit");
    wake_irq = 1; step(1); wake_irq = 0;
    cmp(wait_exit, 1, "R7 wake exit"); cmp(rst_seq_start, 0, "R7 wake no rss");

    // R3 monitor reset
    mon_en = 1; pll_off_wait = 0; step(1); enter_wait();
    cmp(pll_on, 1, "R12 pll kept");
    pulse_fail();
    cmp(mon_rst_req, 1, "R3 pulse"); step(1);
    cmp(mon_rst_req, 0, "R3 single");

    // R4/R5/R6 self-clock in wait, irq disabled
    scm_en = 1; pll_off_wait = 1; step(1); enter_wait(); pulse_fail();
    cmp(scm_active, 1, "R4 scm"); cmp(scm_flag, 1, "R4 flag");
    cmp(pll_on, 1, "R4 pll"); cmp(vreg_on, 1, "R4 vreg");
    cmp(scm_irq, 0, "R9 irq masked"); cmp(wait_exit, 0, "R4 no exit");
    osc_tick = 1; step(100); osc_tick = 0;
    pulse_fail();
    osc_tick = 1; step(LEN - 1);
    cmp(scm_active, 1, "R5 not yet");
    step(1); osc_tick = 0;
    cmp(scm_active, 0, "R5 pass"); cmp(vreg_on, 1, "R6 vreg");
    cmp(pll_on, 0, "R6 pll off"); cmp(wait_exit, 0, "R6 stays");
    wake_irq = 1; step(1); wake_irq = 0;
    cmp(wait_exit, 1, "R7 exit"); cmp(sysclk_pll, 0, "R7 osc");

    // R9 clear, R8/R10 exit while self-clocked
    flag_clr = 1; step(1); flag_clr = 0;
    cmp(scm_flag, 0, "R9 clear");
    scm_irq_en = 1; pll_off_wait = 0; enter_wait(); pulse_fail();
    cmp(scm_irq, 1, "R9 irq");
    flag_clr = 1; clk_fail = 1; step(1); flag_clr = 0; clk_fail = 0;
    cmp(scm_flag, 0, "R9 clr only");
    ext_rst = 1; wake_irq = 1; step(1); ext_rst = 0; wake_irq = 0;
    cmp(rst_seq_start, 1, "R10 reset path"); cmp(sysclk_pll, 1, "R8 pll sel");
    cmp(scm_active, 1, "R8 still scm");
    for (int i = 0; i < LEN; i++) begin
      osc_tick = 1; step(1); osc_tick = 0; step(1);
    end
    cmp(sysclk_pll, 0, "R8 back to osc"); cmp(scm_active, 0, "R8 scm off");

    // R7 reset exit with oscillator good
    enter_wait(); ext_rst = 1; step(1); ext_rst = 0;
    cmp(rst_seq_start, 1, "R7 rss"); cmp(sysclk_pll, 0, "R11 osc");
    step(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule